// File: doc/BRIEF.md
# Overcurrent Pulse Limiter with Delayed-Window Shutdown

This block sits between a current-sense comparator and the PWM gate logic of a switching regulator. In every switching period the comparator result is offered as a strobed flag. When the flag reports overcurrent, the block raises a one-cycle request that cuts the present PWM pulse short. This limits the inductor current on a cycle-by-cycle basis.

The first overcurrent event also starts a window timer. Further overcurrent events that arrive before the window opens only cut their own pulses. An overcurrent event that arrives while the window is open means the fault persists, so the block latches a shutdown. If the window closes with no such event, the timer returns to idle and the next event starts a new measurement.

The window bounds are parameters counted in clock ticks. Real millisecond-scale windows and short simulation windows therefore use the same code. Driving the enable low clears the latched shutdown and the timer.

Top module: `ocl_current_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs `pulse_kill`, `oc_shutdown` and `timer_active` are all 0 after that edge.
- R2: A qualified overcurrent event is `sample_valid`=1, `oc_flag`=1, `enable`=1 and `oc_shutdown`=0 at a clock edge. Such an event drives `pulse_kill` to 1 for exactly the following cycle. Without an event, `pulse_kill` is 0.
- R3: A qualified event while `timer_active` is 0 sets `timer_active` to 1 after that edge. That edge is offset 0 of the timer.
- R4: A qualified event at an offset k with 1 <= k < WIN_OPEN cuts the pulse. It neither latches shutdown nor restarts the timer.
- R5: A qualified event at an offset k with WIN_OPEN <= k <= WIN_CLOSE sets `oc_shutdown` to 1 and `timer_active` to 0 after that edge. This includes both bounds.
- R6: With no qualified event in the window, `timer_active` is 1 after the edges at offsets 1 to WIN_CLOSE-1 and 0 after the edge at offset WIN_CLOSE. A later event then starts a fresh timer at offset 0 without shutdown.
- R7: Once set, `oc_shutdown` stays 1 while `enable` is 1, whatever `oc_flag` does. While it is held, `pulse_kill` stays 0.
- R8: `enable`=0 at an edge clears `oc_shutdown`, `timer_active` and `pulse_kill` after that edge. Overcurrent samples taken with `enable`=0 neither cut a pulse nor start the timer.
- R9: `oc_flag` is ignored in any cycle where `sample_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low clears the limiter state |
| sample_valid | input | 1 | Strobe marking a valid comparator sample |
| oc_flag | input | 1 | Sampled overcurrent comparator result |
| pulse_kill | output | 1 | Registered request to end the current PWM pulse |
| oc_shutdown | output | 1 | Latched overcurrent shutdown |
| timer_active | output | 1 | Window timer is running |

## Verification
The bench builds the block with WIN_OPEN=4 and WIN_CLOSE=8. With these values every offset inside and around the window can be reached in a handful of cycles. Both edges of the window are exercised: offset 3 must not trip, while offsets 4 and 8 must trip. The bench also checks the timer expiring at offset 8 followed by a fresh start. Clearing by enable is tested both during a held shutdown and in the middle of a running window.

// File: rtl/ocl_pkg.sv
package ocl_pkg;
  typedef enum logic {TMR_IDLE = 1'b0, TMR_RUN = 1'b1} tmr_state_t;

  localparam int DEF_WIN_OPEN  = 26;
  localparam int DEF_WIN_CLOSE = 53;
endpackage

// File: rtl/ocl_window_timer.sv
module ocl_window_timer
  import ocl_pkg::*;
#(
  parameter int WIN_OPEN  = DEF_WIN_OPEN,
  parameter int WIN_CLOSE = DEF_WIN_CLOSE,
  parameter int CW        = $clog2(WIN_CLOSE + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  input  logic trip,
  output logic active,
  output logic in_window
);
  localparam logic [CW-1:0] OPEN_C  = CW'(WIN_OPEN);
  localparam logic [CW-1:0] CLOSE_C = CW'(WIN_CLOSE);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  tmr_state_t    state;
  logic [CW-1:0] cnt;

  // Offset counter: holds k while the cycle k edges after the start is open.
  always_ff @(posedge clk) begin
    if (rst || clr || trip) begin
      state <= TMR_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        TMR_IDLE: if (start) begin
          state <= TMR_RUN;
          cnt   <= ONE_C;
        end
        TMR_RUN: if (cnt == CLOSE_C) begin
          state <= TMR_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + ONE_C;
        end
        default: state <= TMR_IDLE;
      endcase
    end
  end

  assign active    = (state == TMR_RUN);
  assign in_window = (state == TMR_RUN) && (cnt >= OPEN_C) && (cnt <= CLOSE_C);
endmodule

// File: rtl/ocl_trip_latch.sv
module ocl_trip_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (set)   q <= 1'b1;
  end
endmodule

// File: rtl/ocl_current_guard.sv
module ocl_current_guard
  import ocl_pkg::*;
#(
  parameter int WIN_OPEN  = DEF_WIN_OPEN,
  parameter int WIN_CLOSE = DEF_WIN_CLOSE
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic sample_valid,
  input  logic oc_flag,
  output logic pulse_kill,
  output logic oc_shutdown,
  output logic timer_active
);
  localparam int CW = $clog2(WIN_CLOSE + 1);

  logic oc_evt;
  logic in_window;
  logic trip;
  logic kill_q;

  assign oc_evt = sample_valid && oc_flag && enable && !oc_shutdown;
  assign trip   = oc_evt && in_window;

  ocl_window_timer #(
    .WIN_OPEN (WIN_OPEN),
    .WIN_CLOSE(WIN_CLOSE),
    .CW       (CW)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (!enable),
    .start    (oc_evt),
    .trip     (trip),
    .active   (timer_active),
    .in_window(in_window)
  );

  ocl_trip_latch u_latch (
    .clk(clk),
    .rst(rst),
    .clr(!enable),
    .set(trip),
    .q  (oc_shutdown)
  );

  always_ff @(posedge clk) begin
    if (rst) kill_q <= 1'b0;
    else     kill_q <= oc_evt;
  end

  assign pulse_kill = kill_q;
endmodule

// File: rtl/ocl_current_guard_chk.sv
module ocl_current_guard_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic sample_valid,
  input logic oc_flag,
  input logic pulse_kill,
  input logic oc_shutdown,
  input logic timer_active
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!pulse_kill && !oc_shutdown && !timer_active));

  p_kill_follows_oc_r2: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && oc_flag && enable && !oc_shutdown) |=> pulse_kill);

  p_kill_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_kill |-> $past(sample_valid && oc_flag && enable));

  p_timer_starts_r3: assert property (@(posedge clk) disable iff (rst)
    (!timer_active && sample_valid && oc_flag && enable && !oc_shutdown) |=> timer_active);

  p_trip_needs_timer_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(oc_shutdown) |-> $past(sample_valid && oc_flag && timer_active));

  p_sd_stops_timer_r5: assert property (@(posedge clk) disable iff (rst)
    oc_shutdown |-> !timer_active);

  p_sd_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (oc_shutdown && enable) |=> oc_shutdown);

  p_no_kill_in_sd_r7: assert property (@(posedge clk) disable iff (rst)
    (oc_shutdown && $past(oc_shutdown)) |-> !pulse_kill);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!oc_shutdown && !timer_active && !pulse_kill));
endmodule

bind ocl_current_guard ocl_current_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .sample_valid(sample_valid),
  .oc_flag     (oc_flag),
  .pulse_kill  (pulse_kill),
  .oc_shutdown (oc_shutdown),
  .timer_active(timer_active)
);

// File: tb/sim_ocl_current_guard.sv
module sim_ocl_current_guard;
  localparam int OPEN  = 4;
  localparam int CLOSE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic sample_valid = 1'b0;
  logic oc_flag = 1'b0;
  logic pulse_kill, oc_shutdown, timer_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  ocl_current_guard #(.WIN_OPEN(OPEN), .WIN_CLOSE(CLOSE)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .sample_valid(sample_valid),
    .oc_flag(oc_flag), .pulse_kill(pulse_kill), .oc_shutdown(oc_shutdown),
    .timer_active(timer_active)
  );

  // Driver: set inputs for the coming edge and queue the expected outputs.
  task automatic step(input logic r, input logic e, input logic v, input logic o,
                      input logic ek, input logic es, input logic ea, input string tag);
    @(negedge clk);
    rst = r; enable = e; sample_valid = v; oc_flag = o;
    exp_q.push_back({ek, es, ea});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare outputs shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [2:0] ex;
      logic [2:0] got;
      string t;
      ex = exp_q.pop_front();
      t  = tag_q.pop_front();
      got = {pulse_kill, oc_shutdown, timer_active};
      checks++;
      if (got !== ex) begin
        errors++;
        $display("FAIL %s: kill/sd/act actual=%b expected=%b", t, got, ex);
      end
    end
  end

  initial begin
    // R1 reset
    step(1, 1, 1, 1, 0, 0, 0, "R1 reset");
    step(1, 1, 1, 1, 0, 0, 0, "R1 reset");
    step(0, 1, 0, 0, 0, 0, 0, "R1 idle after reset");
    // R9 flag without strobe
    step(0, 1, 0, 1, 0, 0, 0, "R9 flag ignored");
    // R2/R3 first event, then R6 expiry
    step(0, 1, 1, 1, 1, 0, 1, "R2 R3 first event");
    for (int k = 1; k < CLOSE; k++) step(0, 1, 0, 1, 0, 0, 1, "R6 timer running");
    step(0, 1, 0, 0, 0, 0, 0, "R6 expiry at close");
    // R4 early hit, R5 trip at open bound
    step(0, 1, 1, 1, 1, 0, 1, "R3 start");
    step(0, 1, 1, 1, 1, 0, 1, "R4 early hit k=1");
    step(0, 1, 0, 0, 0, 0, 1, "R4 k=2");
    step(0, 1, 0, 0, 0, 0, 1, "R4 k=3");
    step(0, 1, 1, 1, 1, 1, 0, "R5 trip at open");
    // R7 hold
    step(0, 1, 1, 1, 0, 1, 0, "R7 held, no kill");
    step(0, 1, 1, 1, 0, 1, 0, "R7 held, no kill");
    step(0, 1, 0, 0, 0, 1, 0, "R7 held idle");
    // R8 clear and ignore while disabled
    step(0, 0, 1, 1, 0, 0, 0, "R8 clear by enable");
    step(0, 0, 1, 1, 0, 0, 0, "R8 ignored while disabled");
    // R5 trip at close bound
    step(0, 1, 1, 1, 1, 0, 1, "R3 start");
    for (int k = 1; k < CLOSE; k++) step(0, 1, 0, 0, 0, 0, 1, "R5 waiting");
    step(0, 1, 1, 1, 1, 1, 0, "R5 trip at close");
    step(0, 0, 0, 0, 0, 0, 0, "R8 clear");
    // R4 hit at open-1, then expiry and fresh start (R6)
    step(0, 1, 1, 1, 1, 0, 1, "R3 start");
    step(0, 1, 0, 0, 0, 0, 1, "R4 k=1");
    step(0, 1, 0, 0, 0, 0, 1, "R4 k=2");
    step(0, 1, 1, 1, 1, 0, 1, "R4 hit at open-1");
    for (int k = OPEN; k < CLOSE; k++) step(0, 1, 0, 0, 0, 0, 1, "R4 timer not restarted");
    step(0, 1, 0, 0, 0, 0, 0, "R6 expiry");
    step(0, 1, 1, 1, 1, 0, 1, "R6 fresh start");
    step(0, 1, 1, 1, 1, 0, 1, "R6 fresh k=1 no trip");
    // R8 enable low mid-window
    step(0, 0, 0, 0, 0, 0, 0, "R8 timer cleared");
    step(0, 1, 0, 0, 0, 0, 0, "R8 stays idle");
    step(0, 1, 1, 1, 1, 0, 1, "R3 restart after clear");
    step(0, 1, 0, 0, 0, 0, 1, "R6 k=1");
    step(0, 1, 1, 0, 0, 0, 1, "R2 no kill without flag");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule